// File: doc/BRIEF.md
# Instruction Synchronization Packet Parser

This block takes a trace byte stream, one byte per accepted cycle, and decodes the packets that restore an absolute program counter and processor state to a trace decoder. Two header values open a packet. One header is followed directly by an information byte. The other is followed first by a variable-length cycle count and then by the information byte. In both forms a 4-byte little-endian address comes last. The block assumes that no context identifier field is present.

When the last address byte is accepted, the block registers the decoded fields and raises a one-cycle done strobe. The fields are the cleaned address, the sync reason, the instruction-set state, the security, alternate-ISA and hypervisor flags, the cycle count with its valid flag, and an unsupported-variant flag. The block also keeps a tracked program counter and a last-branch address. Other decoder logic may overwrite the tracked program counter. A periodic sync whose address disagrees with the tracked value raises a warning strobe.

Top module: `isync_parser`

## Requirements
- R1: While idle, only byte 0x08 (plain form) or 0x70 (counted form) opens a packet. Every other accepted byte is discarded and leaves all outputs unchanged.
- R2: Plain form is header, information byte, then address bytes 0 to 3, least significant first. `done` is high in the cycle after the edge that accepts address byte 3.
- R3: In the counted form, 1 to 5 count bytes follow the header. Each count byte carries 7 value bits in bits 6:0, lowest group first. Bit 7 set means another count byte follows. The fifth count byte always ends the count, whatever its bit 7. `cyc_count` takes the lower 32 bits and `cyc_valid` is 1. The plain form gives `cyc_valid`=0 and `cyc_count`=0.
- R4: `reason` equals information-byte bits 6:5 (0 periodic, 1 trace enabled, 2 after overflow, 3 exit from debug).
- R5: `nonsec`, `alt_isa` and `hyp` equal information-byte bits 3, 2 and 1.
- R6: `isa_state` is 2 (bytecode) if information-byte bit 4 is set. Otherwise it is 1 (compact) if address bit 0 is set, and otherwise 0 (word). `sync_addr` is the address with bit 0 cleared.
- R7: `pc_mismatch` is high together with `done` exactly when `reason` is 0 and `sync_addr` differs from the tracked program counter held just before that packet ended. It is never high at any other time.
- R8: At packet end, `tracked_pc` and `last_branch` both load `sync_addr`. Outside packet end, `trk_wr_en` loads `trk_wr_pc` into `tracked_pc` only. At packet end, the sync load wins over a concurrent write.
- R9: `lsip` equals information-byte bit 7 (load/store-in-progress variant, flagged as unsupported).
- R10: `done` lasts one cycle. The decoded outputs hold their values until the next packet ends.
- R11: Reset clears all outputs to 0, aborts any partial packet and returns the parser to idle.
- R12: Cycles with `byte_valid` low change nothing, whatever the value of `byte_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | `byte_data` is accepted this cycle |
| byte_data | input | 8 | Trace stream byte |
| trk_wr_en | input | 1 | External write of the tracked program counter |
| trk_wr_pc | input | 32 | Value for the external write |
| done | output | 1 | One-cycle strobe when a packet has been decoded |
| sync_addr | output | 32 | Decoded address, bit 0 cleared |
| reason | output | 2 | Sync reason code |
| isa_state | output | 2 | 0 word, 1 compact, 2 bytecode |
| nonsec | output | 1 | Non-secure flag |
| alt_isa | output | 1 | Alternate-ISA flag |
| hyp | output | 1 | Hypervisor flag |
| lsip | output | 1 | Unsupported load/store-in-progress variant |
| cyc_count | output | 32 | Decoded cycle count |
| cyc_valid | output | 1 | Cycle count present |
| pc_mismatch | output | 1 | Periodic sync disagreed with the tracked program counter |
| tracked_pc | output | 32 | Tracked program counter |
| last_branch | output | 32 | Last branch address |

## Verification
A corrupted phase state or address-byte index would show as a `done` strobe that comes early, late or never. It would also show as address bytes that land in the wrong lanes. Either shows up on the first packet after the fault, in the cycle that the strobe is due. A stale or misaligned cycle-count accumulator shows up in `cyc_count` at the next counted packet. The vectors therefore mix count lengths of one to five groups, including a fifth group whose continuation bit is set. A wrong tracked-PC register shows through the `pc_mismatch` strobe of the next periodic sync and through `tracked_pc` at once.

// File: rtl/isync_pkg.sv
package isync_pkg;

  localparam logic [7:0] HDR_PLAIN = 8'h08;
  localparam logic [7:0] HDR_CYC   = 8'h70;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_CYC  = 2'd1,
    PS_INFO = 2'd2,
    PS_ADDR = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    ISA_WORD     = 2'd0,
    ISA_COMPACT  = 2'd1,
    ISA_BYTECODE = 2'd2
  } isa_e;

  typedef struct packed {
    logic       lsip;
    logic [1:0] reason;
    logic       nonsec;
    logic       altisa;
    logic       hyp;
  } info_t;

endpackage

// File: rtl/isync_varint.sv
// Accumulates a little-endian 7-bit-group count with continuation flags.
module isync_varint #(
  parameter int CNT_W     = 32,
  parameter int MAX_BYTES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [7:0]       din,
  output logic [CNT_W-1:0] value,
  output logic             last
);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int SH_W  = 7 * MAX_BYTES;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_BYTES - 1);

  logic [CNT_W-1:0] acc_q, acc_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    acc_d = acc_q;
    idx_d = idx_q;
    if (clr) begin
      acc_d = '0;
      idx_d = '0;
    end else if (en) begin
      acc_d = acc_q | CNT_W'(SH_W'(din[6:0]) << (7 * idx_q));
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (clr || en) begin
      acc_q <= acc_d;
      idx_q <= idx_d;
    end
  end

  assign value = acc_q;
  assign last  = !din[7] || (idx_q == IDX_LAST);
endmodule

// File: rtl/isync_info_dec.sv
// Splits the information byte and resolves the instruction-set state.
module isync_info_dec
  import isync_pkg::*;
(
  input  logic [7:1] info_bits,
  input  logic       addr_lsb,
  output info_t      fields,
  output isa_e       isa
);
  always_comb begin
    fields.lsip   = info_bits[7];
    fields.reason = info_bits[6:5];
    fields.nonsec = info_bits[3];
    fields.altisa = info_bits[2];
    fields.hyp    = info_bits[1];
    if (info_bits[4])  isa = ISA_BYTECODE;
    else if (addr_lsb) isa = ISA_COMPACT;
    else               isa = ISA_WORD;
  end
endmodule

// File: rtl/isync_pc_track.sv
// Holds the tracked program counter and last branch address.
module isync_pc_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              ext_wr_en,
  input  logic [ADDR_W-1:0] ext_wr_pc,
  output logic [ADDR_W-1:0] tracked_pc,
  output logic [ADDR_W-1:0] last_branch
);
  logic [ADDR_W-1:0] trk_q, trk_d, lbr_q;
  logic              trk_en;

  always_comb begin
    trk_en = load_en || ext_wr_en;
    trk_d  = load_en ? load_addr : ext_wr_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trk_q <= '0;
    else if (trk_en) trk_q <= trk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lbr_q <= '0;
    else if (load_en) lbr_q <= load_addr;
  end

  assign tracked_pc  = trk_q;
  assign last_branch = lbr_q;
endmodule

// File: rtl/isync_parser.sv
module isync_parser
  import isync_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 32,
  parameter int CNT_MAX_BYTES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              trk_wr_en,
  input  logic [ADDR_W-1:0] trk_wr_pc,
  output logic              done,
  output logic [ADDR_W-1:0] sync_addr,
  output logic [1:0]        reason,
  output logic [1:0]        isa_state,
  output logic              nonsec,
  output logic              alt_isa,
  output logic              hyp,
  output logic              lsip,
  output logic [CNT_W-1:0]  cyc_count,
  output logic              cyc_valid,
  output logic              pc_mismatch,
  output logic [ADDR_W-1:0] tracked_pc,
  output logic [ADDR_W-1:0] last_branch
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AIDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int LO_W       = ADDR_W - 8;
  localparam logic [AIDX_W-1:0] AIDX_LAST = AIDX_W'(ADDR_BYTES - 1);

  pstate_e            st_q, st_d;
  logic [AIDX_W-1:0]  aidx_q, aidx_d;
  logic [LO_W-1:0]    lo_q, lo_d;
  logic [7:1]         info_q, info_d;
  logic               cychdr_q, cychdr_d;
  logic               cnt_clr, cnt_en, cnt_last, fin, mism;
  logic [CNT_W-1:0]   cnt_val;
  logic [ADDR_W-1:0]  full_addr, clean_addr;
  info_t              fields;
  isa_e               isa;

  // output registers
  logic               done_q, mism_q, ns_q, alt_q, hyp_q, lsip_q, cv_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [1:0]         reason_q, isa_q;
  logic [CNT_W-1:0]   cnt_q;

  isync_varint #(.CNT_W(CNT_W), .MAX_BYTES(CNT_MAX_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .din(byte_data), .value(cnt_val), .last(cnt_last)
  );

  assign full_addr  = {byte_data, lo_q};
  assign clean_addr = {full_addr[ADDR_W-1:1], 1'b0};

  isync_info_dec u_dec (
    .info_bits(info_q), .addr_lsb(full_addr[0]), .fields(fields), .isa(isa)
  );

  isync_pc_track #(.ADDR_W(ADDR_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .load_en(fin), .load_addr(clean_addr),
    .ext_wr_en(trk_wr_en), .ext_wr_pc(trk_wr_pc),
    .tracked_pc(tracked_pc), .last_branch(last_branch)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    aidx_d   = aidx_q;
    lo_d     = lo_q;
    info_d   = info_q;
    cychdr_d = cychdr_q;
    cnt_clr  = 1'b0;
    cnt_en   = 1'b0;
    fin      = 1'b0;
    case (st_q)
      PS_IDLE: begin
        if (byte_valid && (byte_data == HDR_PLAIN || byte_data == HDR_CYC)) begin
          cnt_clr  = 1'b1;
          cychdr_d = (byte_data == HDR_CYC);
          st_d     = (byte_data == HDR_CYC) ? PS_CYC : PS_INFO;
        end
      end
      PS_CYC: begin
        if (byte_valid) begin
          cnt_en = 1'b1;
          if (cnt_last) st_d = PS_INFO;
        end
      end
      PS_INFO: begin
        if (byte_valid) begin
          info_d = byte_data[7:1];
          aidx_d = '0;
          st_d   = PS_ADDR;
        end
      end
      PS_ADDR: begin
        if (byte_valid) begin
          lo_d   = {byte_data, lo_q[LO_W-1:8]};
          aidx_d = aidx_q + AIDX_W'(1);
          if (aidx_q == AIDX_LAST) begin
            fin  = 1'b1;
            st_d = PS_IDLE;
          end
        end
      end
      default: st_d = PS_IDLE;
    endcase
    mism = (fields.reason == 2'd0) && (clean_addr != tracked_pc);
  end

  // parser state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_IDLE;
      aidx_q   <= '0;
      lo_q     <= '0;
      info_q   <= '0;
      cychdr_q <= 1'b0;
    end else if (byte_valid) begin
      st_q     <= st_d;
      aidx_q   <= aidx_d;
      lo_q     <= lo_d;
      info_q   <= info_d;
      cychdr_q <= cychdr_d;
    end
  end

  // strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      mism_q <= 1'b0;
    end else begin
      done_q <= fin;
      mism_q <= fin && mism;
    end
  end

  // decoded field registers, enabled at packet end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      reason_q <= '0;
      isa_q    <= '0;
      ns_q     <= 1'b0;
      alt_q    <= 1'b0;
      hyp_q    <= 1'b0;
      lsip_q   <= 1'b0;
      cnt_q    <= '0;
      cv_q     <= 1'b0;
    end else if (fin) begin
      addr_q   <= clean_addr;
      reason_q <= fields.reason;
      isa_q    <= isa;
      ns_q     <= fields.nonsec;
      alt_q    <= fields.altisa;
      hyp_q    <= fields.hyp;
      lsip_q   <= fields.lsip;
      cnt_q    <= cychdr_q ? cnt_val : '0;
      cv_q     <= cychdr_q;
    end
  end

  assign done        = done_q;
  assign pc_mismatch = mism_q;
  assign sync_addr   = addr_q;
  assign reason      = reason_q;
  assign isa_state   = isa_q;
  assign nonsec      = ns_q;
  assign alt_isa     = alt_q;
  assign hyp         = hyp_q;
  assign lsip        = lsip_q;
  assign cyc_count   = cnt_q;
  assign cyc_valid   = cv_q;
endmodule

// File: rtl/isync_parser_chk.sv
module isync_parser_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              pc_mismatch,
  input logic [1:0]        reason,
  input logic [ADDR_W-1:0] sync_addr,
  input logic [ADDR_W-1:0] tracked_pc,
  input logic [ADDR_W-1:0] last_branch
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_WARN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_mismatch == ((reason == 2'd0) && (sync_addr != $past(tracked_pc))))); // R7

  AST_WARN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !pc_mismatch); // R7

  AST_ADDR_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sync_addr[0]); // R6

  AST_TRACK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tracked_pc == sync_addr) && (last_branch == sync_addr)); // R8
endmodule

bind isync_parser isync_parser_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .pc_mismatch(pc_mismatch),
  .reason(reason), .sync_addr(sync_addr), .tracked_pc(tracked_pc),
  .last_branch(last_branch)
);

// File: tb/tb_isync_parser.sv
`timescale 1ns/1ps
module tb_isync_parser;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        trk_wr_en;
  logic [31:0] trk_wr_pc;
  logic        done, nonsec, alt_isa, hyp, lsip, cyc_valid, pc_mismatch;
  logic [31:0] sync_addr, cyc_count, tracked_pc, last_branch;
  logic [1:0]  reason, isa_state;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  isync_parser dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .trk_wr_en(trk_wr_en), .trk_wr_pc(trk_wr_pc), .done(done),
    .sync_addr(sync_addr), .reason(reason), .isa_state(isa_state),
    .nonsec(nonsec), .alt_isa(alt_isa), .hyp(hyp), .lsip(lsip),
    .cyc_count(cyc_count), .cyc_valid(cyc_valid), .pc_mismatch(pc_mismatch),
    .tracked_pc(tracked_pc), .last_branch(last_branch)
  );

  // {hdr, cc, nb, info, addr, pre}
  localparam int NV = 8;
  localparam logic [114:0] VEC [NV] = '{
    {8'h08, 32'h0,        3'd0, 8'h00, 32'h0000_1000, 32'h0000_1000},
    {8'h08, 32'h0,        3'd0, 8'h00, 32'h0000_2001, 32'h0000_2000},
    {8'h08, 32'h0,        3'd0, 8'h00, 32'h0000_3000, 32'h0000_4000},
    {8'h70, 32'h5,        3'd1, 8'h20, 32'h8000_0000, 32'h0000_0000},
    {8'h70, 32'h3FFF,     3'd2, 8'h40, 32'h1234_5679, 32'h0000_0010},
    {8'h70, 32'hDEAD_BEEF,3'd5, 8'h7E, 32'hCAFE_F00D, 32'h0000_0000},
    {8'h70, 32'h80,       3'd3, 8'h8C, 32'h0000_0100, 32'h0000_0100},
    {8'h08, 32'h0,        3'd0, 8'h12, 32'h0000_0055, 32'h0000_0054}
  };

  logic [7:0] pk [16];
  int pn;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  task automatic build(input logic [7:0] hdr, input logic [31:0] cc, input int nb,
                       input logic [7:0] info, input logic [31:0] addr);
    logic [63:0] w;
    pn = 0;
    pk[pn] = hdr; pn++;
    if (hdr == 8'h70) begin
      for (int g = 0; g < nb; g++) begin
        w = {32'h0, cc} >> (7 * g);
        pk[pn] = {(g < nb - 1), w[6:0]}; pn++;
      end
    end
    pk[pn] = info; pn++;
    for (int b = 0; b < 4; b++) begin
      pk[pn] = addr[8*b +: 8]; pn++;
    end
  endtask

  task automatic ext_wr(input logic [31:0] v);
    @(negedge clk); trk_wr_en = 1'b1; trk_wr_pc = v;
    @(negedge clk); trk_wr_en = 1'b0;
  endtask

  // Leaves the bench at the negedge after the last byte was accepted.
  task automatic drive(input bit gaps, input bit wr_last, input logic [31:0] wv);
    for (int i = 0; i < pn; i++) begin
      if (gaps && i > 0) begin
        @(negedge clk); byte_valid = 1'b0; byte_data = 8'h70;
      end
      @(negedge clk); byte_valid = 1'b1; byte_data = pk[i];
      if (wr_last && i == pn - 1) begin
        trk_wr_en = 1'b1; trk_wr_pc = wv;
      end
    end
    @(negedge clk); byte_valid = 1'b0; trk_wr_en = 1'b0;
  endtask

  task automatic expect_pkt(input logic [7:0] hdr, input logic [31:0] cc,
                            input logic [7:0] info, input logic [31:0] addr,
                            input logic [31:0] pre);
    logic [31:0] ea;
    logic [1:0]  ei;
    logic        em;
    ea = {addr[31:1], 1'b0};
    ei = info[4] ? 2'd2 : (addr[0] ? 2'd1 : 2'd0);
    em = (info[6:5] == 2'd0) && (ea != pre);
    check("R2 done strobe", {31'h0, done}, 32'h1);
    check("R6 sync_addr", sync_addr, ea);
    check("R6 isa_state", {30'h0, isa_state}, {30'h0, ei});
    check("R4 reason", {30'h0, reason}, {30'h0, info[6:5]});
    check("R5 flags", {29'h0, nonsec, alt_isa, hyp}, {29'h0, info[3:1]});
    check("R9 lsip", {31'h0, lsip}, {31'h0, info[7]});
    check("R3 cyc_valid", {31'h0, cyc_valid}, {31'h0, hdr == 8'h70});
    check("R3 cyc_count", cyc_count, (hdr == 8'h70) ? cc : 32'h0);
    check("R7 pc_mismatch", {31'h0, pc_mismatch}, {31'h0, em});
    check("R8 tracked_pc", tracked_pc, ea);
    check("R8 last_branch", last_branch, ea);
    @(negedge clk);
    check("R10 done one cycle", {31'h0, done}, 32'h0);
    check("R7 mismatch one cycle", {31'h0, pc_mismatch}, 32'h0);
    check("R10 addr held", sync_addr, ea);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; byte_valid = 1'b0; byte_data = 8'h0;
    trk_wr_en = 1'b0; trk_wr_pc = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 done", {31'h0, done}, 32'h0);
    check("R11 sync_addr", sync_addr, 32'h0);
    check("R11 tracked_pc", tracked_pc, 32'h0);
    check("R11 cyc_valid", {31'h0, cyc_valid}, 32'h0);
    check("R11 isa/reason", {28'h0, isa_state, reason}, 32'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  hdr, info;
      logic [31:0] cc, addr, pre;
      logic [2:0]  nb;
      {hdr, cc, nb, info, addr, pre} = VEC[v];
      ext_wr(pre);
      build(hdr, cc, int'(nb), info, addr);
      drive(1'b0, 1'b0, 32'h0);
      expect_pkt(hdr, cc, info, addr, pre);
    end

    // R12 gaps with a header value on the bus while valid is low
    ext_wr(32'h0000_0010);
    build(8'h70, 32'h3FFF, 2, 8'h40, 32'h1234_5679);
    drive(1'b1, 1'b0, 32'h0);
    expect_pkt(8'h70, 32'h3FFF, 8'h40, 32'h1234_5679, 32'h0000_0010);

    // R3 fifth count byte with continuation set still ends the count
    pn = 0;
    pk[pn] = 8'h70; pn++;
    for (int g = 0; g < 5; g++) begin pk[pn] = 8'hFF; pn++; end
    pk[pn] = 8'h60; pn++;
    pk[pn] = 8'h44; pn++; pk[pn] = 8'h33; pn++; pk[pn] = 8'h22; pn++; pk[pn] = 8'h11; pn++;
    drive(1'b0, 1'b0, 32'h0);
    expect_pkt(8'h70, 32'hFFFF_FFFF, 8'h60, 32'h1122_3344, 32'h0);

    // R1 non-header bytes in idle are discarded
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); byte_valid = 1'b1;
      byte_data = (j == 0) ? 8'h55 : (j == 1) ? 8'h00 : (j == 2) ? 8'h09 : 8'h71;
      @(negedge clk); byte_valid = 1'b0;
      check("R1 no done on junk", {31'h0, done}, 32'h0);
      check("R1 outputs unchanged", sync_addr, 32'h1122_3344);
    end
    ext_wr(32'hAAAA_0000);
    build(8'h08, 32'h0, 0, 8'h00, 32'hAAAA_0000);
    drive(1'b0, 1'b0, 32'h0);
    expect_pkt(8'h08, 32'h0, 8'h00, 32'hAAAA_0000, 32'hAAAA_0000);

    // R8 sync load wins over a concurrent external write
    ext_wr(32'h1111_0000);
    build(8'h08, 32'h0, 0, 8'h20, 32'h0000_0A00);
    drive(1'b0, 1'b1, 32'h9999_0000);
    expect_pkt(8'h08, 32'h0, 8'h20, 32'h0000_0A00, 32'h1111_0000);
    ext_wr(32'h0BAD_0000);
    check("R8 ext write tracked", tracked_pc, 32'h0BAD_0000);
    check("R8 ext write leaves last_branch", last_branch, 32'h0000_0A00);

    // R11 reset aborts a partial packet
    build(8'h08, 32'h0, 0, 8'h00, 32'h7777_7777);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_data = pk[i];
    end
    @(negedge clk); byte_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R11 cleared after abort", sync_addr, 32'h0);
    check("R11 tracked cleared", tracked_pc, 32'h0);
    build(8'h08, 32'h0, 0, 8'h00, 32'h0000_0004);
    drive(1'b0, 1'b0, 32'h0);
    expect_pkt(8'h08, 32'h0, 8'h00, 32'h0000_0004, 32'h0);

    finished = 1;
    finish_run();
  end
endmodule